// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This block repairs a byte that came out of a plain binary adder fed with two packed-BCD operands. It takes the raw sum, the nibble carry out of the low digit and the adder's carry. It returns a byte that holds valid decimal digits again, along with the updated carry. Each digit position is repaired in turn, starting at the low digit. A digit that is above nine, or whose flag says the binary add already wrapped it, has six added to it. That addition ripples through every higher bit of the word.

The carry output is sticky. A repair can set it but never clears it. The decision for the top digit uses the carry as it stands after the lower repairs, so a carry made by the low-digit repair forces the high-digit repair in the same operation. The overflow flag is carried through unchanged. The digit count is a parameter, with a default of two digits (one byte). The result is registered and appears one clock after a valid strobe. Between strobes the outputs keep their last values.

Top module: `dadj_unit`

## Requirements
- R1: In the low digit (bits 3:0), if the value is greater than 9 or `aux_cy_i[0]` is 1, then 0x06 is added to the whole word. Otherwise nothing is added at this step.
- R2: If a digit repair carries out of the top bit, the carry output is set. If it does not, the carry keeps its incoming value. A carry input of 1 always gives a carry output of 1.
- R3: The top digit is repaired by adding 6 to it when the carry (the input carry, or a carry made by the lower repairs) is 1, or when the top digit after the lower repairs is greater than 9. For example, 0xBE with both flags clear gives 0x24 with carry 1, and 0xC9 gives 0x29 with carry 1.
- R4: The net difference between output and input, taken modulo 2^(4*DIGITS), has every digit equal to 0 or 6. For one byte this is 0x00, 0x06, 0x60 or 0x66.
- R5: `ov_o` takes the value `ov_i` had when it was captured, with no change.
- R6: `vld_o` is 1 exactly in the clock cycle after a cycle with `vld_i` high, and 0 otherwise. The data outputs load only on a cycle with `vld_i` high.
- R7: When `vld_i` is low, `acc_o`, `cy_o` and `ov_o` keep their previous values.
- R8: While `rst_n` is low at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vld_i | input | 1 | Operand strobe |
| acc_i | input | 4*DIGITS (8) | Raw binary sum to be repaired |
| aux_cy_i | input | DIGITS-1 (1) | Carry out of each digit except the top one in the preceding add; bit 0 is the low-nibble carry |
| cy_i | input | 1 | Carry flag from the preceding add |
| ov_i | input | 1 | Overflow flag, passed through |
| vld_o | output | 1 | Result strobe, one clock after `vld_i` |
| acc_o | output | 4*DIGITS (8) | Repaired packed-BCD value |
| cy_o | output | 1 | Updated carry flag |
| ov_o | output | 1 | Overflow flag, unchanged |

## Verification
The two repairs can interact inside one operation. A low-digit repair that wraps the whole word, such as 0xFA with both flags clear, produces a carry that must then trigger the high-digit repair in the same cycle, giving 0x60 with carry set. This case is provoked directly and also arises in a sweep of all 256 bytes under all four flag combinations. Every result is compared against a behavioural integer model that applies the two steps in order. Sticky-carry cases, such as 0x45 with carry 1 giving 0xA5, confirm that a high repair without a carry-out does not clear the flag.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

   localparam int unsigned NIB_W   = 4;
   localparam int unsigned DIG_MAX = 9;
   localparam int unsigned DIG_FIX = 6;

   // True when a 4-bit digit holds a non-decimal code.
   function automatic logic digit_overrange(input logic [NIB_W-1:0] dig);
      return (dig > NIB_W'(DIG_MAX));
   endfunction

   // True when a 4-bit digit of a correction term is legal (0 or 6).
   function automatic logic digit_is_fix(input logic [NIB_W-1:0] dig);
      return (dig == '0) || (dig == NIB_W'(DIG_FIX));
   endfunction

endpackage

// File: rtl/dadj_stage.sv
module dadj_stage
   import dadj_pkg::*;
#(
   parameter int unsigned W   = 8,
   parameter int unsigned POS = 0
) (
   input  logic [W-1:0] word_i,
   input  logic         flag_i,
   input  logic         cy_i,
   output logic [W-1:0] word_o,
   output logic         cy_o
);

   localparam int unsigned LSB = POS * NIB_W;
   localparam logic [W:0]  ADDV = {{(W-3){1'b0}}, 4'(DIG_FIX)} << LSB;

   logic       fix;
   logic [W:0] sum;

   generate
      if (W < NIB_W * (POS + 1)) begin : g_bad_pos
         $error("dadj_stage: digit position outside word");
      end
   endgenerate

   always_comb begin
      fix    = digit_overrange(word_i[LSB +: NIB_W]) || flag_i;
      sum    = {1'b0, word_i} + (fix ? ADDV : '0);
      word_o = sum[W-1:0];
      cy_o   = cy_i | sum[W];
   end

   // R4: a single stage either leaves the word alone or adds 6 at its digit
   always_comb begin
      a_r4_stage_delta : assert ((word_o - word_i) == '0 || (word_o - word_i) == ADDV[W-1:0])
         else $error("stage delta not 0 or 6 at digit");
   end

endmodule

// File: rtl/dadj_core.sv
module dadj_core
   import dadj_pkg::*;
#(
   parameter int unsigned DIGITS = 2
) (
   input  logic [NIB_W*DIGITS-1:0] acc_i,
   input  logic [DIGITS-2:0]       aux_cy_i,
   input  logic                    cy_i,
   output logic [NIB_W*DIGITS-1:0] acc_o,
   output logic                    cy_o
);

   localparam int unsigned W = NIB_W * DIGITS;

   logic [W-1:0] word_q [DIGITS+1];
   logic         cy_q   [DIGITS+1];
   logic         flag   [DIGITS];

   assign word_q[0] = acc_i;
   assign cy_q[0]   = cy_i;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_dig
         if (i == DIGITS - 1) begin : g_top
            // top digit decides on the carry as updated by lower repairs
            assign flag[i] = cy_q[i];
         end else begin : g_low
            assign flag[i] = aux_cy_i[i];
         end
         dadj_stage #(
            .W   (W),
            .POS (i)
         ) i_stage (
            .word_i (word_q[i]),
            .flag_i (flag[i]),
            .cy_i   (cy_q[i]),
            .word_o (word_q[i+1]),
            .cy_o   (cy_q[i+1])
         );
      end
   endgenerate

   assign acc_o = word_q[DIGITS];
   assign cy_o  = cy_q[DIGITS];

   // R4: every digit of the net correction is 0 or 6
   logic [W-1:0] net;
   logic         net_ok;
   always_comb begin
      net    = acc_o - acc_i;
      net_ok = 1'b1;
      for (int k = 0; k < DIGITS; k++) begin
         net_ok = net_ok & digit_is_fix(net[k*NIB_W +: NIB_W]);
      end
      a_r4_net_digits : assert (net_ok) else $error("net correction digit illegal");
      a_r2_cy_sticky_comb : assert (!cy_i || cy_o) else $error("carry cleared");
   end

endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
   import dadj_pkg::*;
#(
   parameter int unsigned DIGITS = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic [4*DIGITS-1:0]     acc_i,
   input  logic [DIGITS-2:0]       aux_cy_i,
   input  logic                    cy_i,
   input  logic                    ov_i,
   output logic                    vld_o,
   output logic [4*DIGITS-1:0]     acc_o,
   output logic                    cy_o,
   output logic                    ov_o
);

   localparam int unsigned W = NIB_W * DIGITS;

   generate
      if (DIGITS < 2) begin : g_bad_digits
         $error("dadj_unit: DIGITS must be at least 2");
      end
   endgenerate

   logic [W-1:0] fix_acc;
   logic         fix_cy;

   dadj_core #(
      .DIGITS (DIGITS)
   ) i_core (
      .acc_i    (acc_i),
      .aux_cy_i (aux_cy_i),
      .cy_i     (cy_i),
      .acc_o    (fix_acc),
      .cy_o     (fix_cy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         acc_o <= '0;
         cy_o  <= 1'b0;
         ov_o  <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            acc_o <= fix_acc;
            cy_o  <= fix_cy;
            ov_o  <= ov_i;
         end
      end
   end

   // R6: result strobe follows the operand strobe by one clock
   a_r6_vld_follow : assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> vld_o);
   a_r6_vld_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> !vld_o);
   // R7: outputs hold without a strobe
   a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> ($stable(acc_o) && $stable(cy_o) && $stable(ov_o)));
   // R5: overflow captured unchanged
   a_r5_ov_pass : assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> (ov_o == $past(ov_i)));
   // R2: an incoming carry is never cleared
   a_r2_cy_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && cy_i) |=> cy_o);

endmodule

// File: tb/test_dadj_unit.sv
module test_dadj_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vld_i = 1'b0;
   logic [7:0] acc_i = '0;
   logic [0:0] aux_cy_i = '0;
   logic       cy_i = 1'b0;
   logic       ov_i = 1'b0;
   logic       vld_o;
   logic [7:0] acc_o;
   logic       cy_o;
   logic       ov_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // expected register state, maintained behaviourally
   int e_vld = 0, e_acc = 0, e_cy = 0, e_ov = 0, e_in = 0;

   always #10 clk = ~clk;

   dadj_unit i_dadj_unit (
      .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .acc_i(acc_i),
      .aux_cy_i(aux_cy_i), .cy_i(cy_i), .ov_i(ov_i),
      .vld_o(vld_o), .acc_o(acc_o), .cy_o(cy_o), .ov_o(ov_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // two-step decimal repair on integers
   function automatic int model(input int a, input int ac, input int c);
      int v = a, cy = c;
      if ((v % 16) > 9 || ac != 0) begin
         v = v + 6;
         if (v > 255) cy = 1;
         v = v % 256;
      end
      if (cy != 0 || (v / 16) > 9) begin
         v = v + 96;
         if (v > 255) cy = 1;
         v = v % 256;
      end
      return cy * 256 + v;
   endfunction

   // compare current outputs with the model, then present next operand
   task automatic step(input string req, input bit v, input int a, input int ac,
                       input int c, input int o);
      int r;
      @(negedge clk);
      chk({req, "/R6 vld"}, vld_o, e_vld);
      chk({req, " acc"}, acc_o, e_acc);
      chk({req, "/R2 cy"}, cy_o, e_cy);
      chk({req, "/R5 ov"}, ov_o, e_ov);
      if (e_vld != 0) begin
         // R4: net correction digits are 0 or 6
         r = (acc_o - e_in) & 255;
         chk("R4 net", ((r % 16 == 0 || r % 16 == 6) && (r / 16 == 0 || r / 16 == 6)), 1);
      end
      vld_i = v; acc_i = a[7:0]; aux_cy_i = ac[0]; cy_i = c[0]; ov_i = o[0];
      e_vld = v;
      if (v) begin
         r = model(a, ac, c);
         e_acc = r % 256; e_cy = r / 256; e_ov = o; e_in = a;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R8: reset state
      chk("R8 vld", vld_o, 0); chk("R8 acc", acc_o, 0);
      chk("R8 cy", cy_o, 0);   chk("R8 ov", ov_o, 0);
      rst_n = 1'b1;
      step("R3", 1, 'hBE, 0, 0, 0);
      step("R3", 1, 'hC9, 0, 0, 1);
      step("R1", 1, 'hFA, 0, 0, 0);
      step("R3", 1, 'h45, 0, 1, 1);
      step("R1", 1, 'h23, 1, 0, 0);
      step("R4", 1, 'h12, 0, 0, 0);
      step("R7", 0, 'h99, 1, 1, 1);
      step("R7", 0, 'h00, 0, 0, 0);
      step("R1", 1, 'h0F, 1, 0, 1);
      step("R2", 1, 'h00, 0, 1, 0);
      // sweep every byte under every flag pair, with idle gaps
      for (int a = 0; a < 256; a++) begin
         for (int f = 0; f < 4; f++) begin
            step("R1/R3", 1, a, f % 2, f / 2, (a + f) % 2);
            if ((a + f) % 5 == 0) step("R7", 0, a ^ 'h5A, 1, 1, 1);
         end
      end
      step("R6", 0, 0, 0, 0, 0);
      step("R6", 0, 0, 0, 0, 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule